// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the front end of a transmit DMA path. Software fills transmit descriptors in a small local descriptor store, one slot per frame. It then moves a 16-bit producer index forward. The engine keeps a 16-bit consumer index. Whenever the two indices differ and both the DMA enable and the ring enable are set, the engine reads the descriptor at its current slot. It decodes the buffer length, the frame flags and the 64-bit buffer address. It presents these to a downstream data mover as a held read request.

When the data mover pulses done, the engine counts the descriptor as consumed and steps to the next slot. The slot pointer is separate from the 16-bit indices and wraps to zero after the last slot of the ring. Memory bursting and frame transmission belong to the data mover and are outside this block.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset the producer index, consumer index and slot pointer all read 0, no request is presented and the engine reports idle.
- R2: While the consumer index equals the producer index, no request is presented.
- R3: Each descriptor is three 32-bit words, selected by word number 0, 1 and 2. Word 0 is the control/status word, word 1 is the low half of the buffer address and word 2 is the high half. The request address is {word 2, word 1} and the request length is bits 27:16 of word 0.
- R4: The request flags come from word 0: start-of-frame is bit 13, end-of-frame is bit 14 and CRC append is bit 6. A descriptor with both frame bits set carries one complete frame in one request.
- R5: Once presented, a request stays valid with unchanged address, length and flags until done is seen, and the consumer index does not move in the meantime.
- R6: A done pulse seen while a request is valid adds one to the consumer index (modulo 2^16) and one to the slot pointer, and the request drops on the following cycle.
- R7: A new descriptor is fetched only when both the DMA enable and the ring enable are 1. If either is 0, pending work waits.
- R8: Clearing an enable while a request is outstanding lets that request complete and be counted. The engine then returns to idle and fetches nothing more until enabled again.
- R9: The slot pointer wraps from the last slot (255 by default) to 0, and the consumer index keeps counting past 255.
- R10: A done pulse while no request is valid leaves the consumer index and slot pointer unchanged.
- R11: Several queued descriptors are served one request at a time in slot order, until the consumer index reaches the producer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor store write strobe |
| desc_slot | input | 8 | Slot being written |
| desc_word | input | 2 | Word within the slot: 0 control, 1 address low, 2 address high |
| desc_wdata | input | 32 | Descriptor word data |
| prod_we | input | 1 | Producer index write strobe |
| prod_wdata | input | 16 | New producer index |
| dma_en | input | 1 | DMA enable |
| ring_en | input | 1 | Enable for the default ring |
| xfer_done | input | 1 | Completion pulse from the data mover |
| req_valid | output | 1 | Read request outstanding |
| req_addr | output | 64 | Buffer address of the request |
| req_len | output | 12 | Buffer length in bytes |
| req_sop | output | 1 | Start-of-frame flag |
| req_eop | output | 1 | End-of-frame flag |
| req_crc | output | 1 | Append-CRC flag |
| prod_idx | output | 16 | Current producer index |
| cons_idx | output | 16 | Current consumer index |
| cur_slot | output | 8 | Slot the engine will fetch next |
| eng_idle | output | 1 | Engine has no descriptor in progress |

## Verification
The assertions assume that software only moves the producer forward, never sets it back onto the consumer while a fetch is under way, and keeps no more than a ring's worth of descriptors outstanding. They also assume that done arrives as a pulse from a data mover that only answers a valid request. The bench keeps to these assumptions: it raises the producer to a later value, writes descriptor words only into slots the engine is not using, and pulses done for one cycle. The single exception is one deliberate stray done, sent while the engine is idle, to exercise R10.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 3;
    localparam int LEN_W      = 12;
    localparam int LEN_LSB    = 16;
    localparam int ADDR_W     = 64;

    // control/status word bit positions
    localparam int BIT_OWN      = 15;
    localparam int BIT_EOP      = 14;
    localparam int BIT_SOP      = 13;
    localparam int BIT_WRAP     = 12;
    localparam int BIT_UNDERRUN = 9;
    localparam int BIT_CRC      = 6;

    // word numbers inside one slot
    localparam logic [1:0] W_CTRL = 2'd0;
    localparam logic [1:0] W_ALO  = 2'd1;
    localparam logic [1:0] W_AHI  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ISSUE = 2'd2
    } txr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              sop;
        logic              eop;
        logic              crc;
    } txr_job_t;

    function automatic txr_job_t txr_decode(input logic [WORD_W-1:0] ctrl,
                                            input logic [WORD_W-1:0] alo,
                                            input logic [WORD_W-1:0] ahi);
        txr_job_t j;
        j.addr = {ahi, alo};
        j.len  = ctrl[LEN_LSB +: LEN_W];
        j.sop  = ctrl[BIT_SOP];
        j.eop  = ctrl[BIT_EOP];
        j.crc  = ctrl[BIT_CRC];
        return j;
    endfunction

endpackage

// File: rtl/txr_desc_store.sv
module txr_desc_store
    import txr_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [1:0]        wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] rd_slot,
    output txr_job_t          rd_job
);

    logic [WORD_W-1:0] rd_q [DESC_WORDS];

    for (genvar w = 0; w < DESC_WORDS; w++) begin : g_bank
        logic [WORD_W-1:0] bank [DEPTH];
        logic [WORD_W-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_word == 2'(w))) begin
                bank[wr_slot] <= wr_data;
            end
            if (rd_en) begin
                q <= bank[rd_slot];
            end
        end

        assign rd_q[w] = q;
    end

    assign rd_job = txr_decode(rd_q[W_CTRL], rd_q[W_ALO], rd_q[W_AHI]);

endmodule

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
    parameter int IDX_W  = 16,
    parameter int DEPTH  = 256,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_we,
    input  logic [IDX_W-1:0]  prod_wdata,
    input  logic              adv,
    output logic [IDX_W-1:0]  prod,
    output logic [IDX_W-1:0]  cons,
    output logic [SLOT_W-1:0] slot,
    output logic              pending
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
            cons <= '0;
            slot <= '0;
        end else begin
            if (prod_we) begin
                prod <= prod_wdata;
            end
            if (adv) begin
                cons <= cons + 1'b1;
                slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
            end
        end
    end

    assign pending = (prod != cons);

    // R9: slot pointer wraps at ring end
    p_slot_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && slot == LAST_SLOT) |=> (slot == '0));

    // R6: consumer steps by exactly one on each advance
    p_cons_step_r6: assert property (@(posedge clk) disable iff (rst)
        adv |=> (cons == IDX_W'($past(cons) + 1'b1)));

endmodule

// File: rtl/txr_ring_seq.sv
module txr_ring_seq
    import txr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go_ok,
    input  logic     pending,
    input  txr_job_t fetched,
    input  logic     done,
    output logic     rd_en,
    output logic     adv,
    output logic     req_valid,
    output txr_job_t job,
    output logic     idle
);

    txr_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            job   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go_ok && pending) begin
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    job   <= fetched;
                    state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (done) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_en     = (state == ST_IDLE) && go_ok && pending;
    assign adv       = (state == ST_ISSUE) && done;
    assign req_valid = (state == ST_ISSUE);
    assign idle      = (state == ST_IDLE);

    // R5: request held steady until done
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !done) |=> (req_valid && $stable(job)));

    // R7: no fetch leaves idle without both enables
    p_en_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (idle && !go_ok) |=> idle);

    // R8: completion always returns to idle
    p_done_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && done) |=> (idle && !req_valid));

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
    import txr_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int IDX_W  = 16,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                desc_we,
    input  logic [SLOT_W-1:0]   desc_slot,
    input  logic [1:0]          desc_word,
    input  logic [WORD_W-1:0]   desc_wdata,
    input  logic                prod_we,
    input  logic [IDX_W-1:0]    prod_wdata,
    input  logic                dma_en,
    input  logic                ring_en,
    input  logic                xfer_done,
    output logic                req_valid,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [LEN_W-1:0]    req_len,
    output logic                req_sop,
    output logic                req_eop,
    output logic                req_crc,
    output logic [IDX_W-1:0]    prod_idx,
    output logic [IDX_W-1:0]    cons_idx,
    output logic [SLOT_W-1:0]   cur_slot,
    output logic                eng_idle
);

    logic     rd_en;
    logic     adv;
    logic     pending;
    logic     go_ok;
    txr_job_t fetched;
    txr_job_t job;

    assign go_ok = dma_en && ring_en;

    txr_desc_store #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_store (
        .clk     (clk),
        .wr_en   (desc_we),
        .wr_slot (desc_slot),
        .wr_word (desc_word),
        .wr_data (desc_wdata),
        .rd_en   (rd_en),
        .rd_slot (cur_slot),
        .rd_job  (fetched)
    );

    txr_ring_index #(.IDX_W(IDX_W), .DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_index (
        .clk        (clk),
        .rst        (rst),
        .prod_we    (prod_we),
        .prod_wdata (prod_wdata),
        .adv        (adv),
        .prod       (prod_idx),
        .cons       (cons_idx),
        .slot       (cur_slot),
        .pending    (pending)
    );

    txr_ring_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go_ok     (go_ok),
        .pending   (pending),
        .fetched   (fetched),
        .done      (xfer_done),
        .rd_en     (rd_en),
        .adv       (adv),
        .req_valid (req_valid),
        .job       (job),
        .idle      (eng_idle)
    );

    assign req_addr = job.addr;
    assign req_len  = job.len;
    assign req_sop  = job.sop;
    assign req_eop  = job.eop;
    assign req_crc  = job.crc;

    // R10: consumer never moves without an outstanding request
    p_cons_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(cons_idx) && $stable(cur_slot));

    // R2: an empty ring stays quiet
    p_empty_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_idle && prod_idx == cons_idx) |=> !req_valid);

endmodule

// File: tb/txd_ring_engine_test.sv
module txd_ring_engine_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_we = 1'b0;
    logic [7:0]  desc_slot = '0;
    logic [1:0]  desc_word = '0;
    logic [31:0] desc_wdata = '0;
    logic        prod_we = 1'b0;
    logic [15:0] prod_wdata = '0;
    logic        dma_en = 1'b0;
    logic        ring_en = 1'b0;
    logic        xfer_done = 1'b0;
    logic        req_valid;
    logic [63:0] req_addr;
    logic [11:0] req_len;
    logic        req_sop, req_eop, req_crc;
    logic [15:0] prod_idx, cons_idx;
    logic [7:0]  cur_slot;
    logic        eng_idle;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txd_ring_engine uut (
        .clk(clk), .rst(rst),
        .desc_we(desc_we), .desc_slot(desc_slot), .desc_word(desc_word),
        .desc_wdata(desc_wdata), .prod_we(prod_we), .prod_wdata(prod_wdata),
        .dma_en(dma_en), .ring_en(ring_en), .xfer_done(xfer_done),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .req_sop(req_sop), .req_eop(req_eop), .req_crc(req_crc),
        .prod_idx(prod_idx), .cons_idx(cons_idx), .cur_slot(cur_slot),
        .eng_idle(eng_idle)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl_word(input logic [11:0] len,
                                             input bit sop, input bit eop, input bit crc);
        logic [31:0] w = '0;
        w[27:16] = len;
        w[13] = sop;
        w[14] = eop;
        w[6]  = crc;
        return w;
    endfunction

    function automatic logic [63:0] wrap_addr(input int s);
        return {32'hA000_0000 + 32'(s), 32'(s) << 4};
    endfunction

    function automatic logic [11:0] wrap_len(input int s);
        return 12'((s * 7 + 3) & 12'hFFF);
    endfunction

    task automatic put_word(input int slot, input logic [1:0] w, input logic [31:0] d);
        desc_we = 1'b1; desc_slot = 8'(slot); desc_word = w; desc_wdata = d;
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic put_desc(input int slot, input logic [31:0] ctl, input logic [63:0] addr);
        put_word(slot, 2'd0, ctl);
        put_word(slot, 2'd1, addr[31:0]);
        put_word(slot, 2'd2, addr[63:32]);
    endtask

    task automatic set_prod(input logic [15:0] v);
        prod_we = 1'b1; prod_wdata = v;
        @(negedge clk);
        prod_we = 1'b0;
    endtask

    task automatic wait_req(output bit got);
        got = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (req_valid) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_valid) seen = 1'b1;
        end
        chk(!seen, tag, 64'(seen), 64'd0);
    endtask

    task automatic pulse_done;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_reset;
        chk(cons_idx == 0 && prod_idx == 0, "R1 indices after reset", {prod_idx, cons_idx}, 0);
        chk(cur_slot == 0, "R1 slot after reset", 64'(cur_slot), 0);
        chk(!req_valid && eng_idle, "R1 idle after reset", {req_valid, eng_idle}, 64'd1);
    endtask

    task automatic t_empty;
        dma_en = 1'b1; ring_en = 1'b1;
        quiet(20, "R2 no request on empty ring");
    endtask

    task automatic t_single;
        bit got;
        logic [63:0] a = 64'h1234_5678_9ABC_DEF0;
        put_desc(0, ctl_word(12'h5EA, 1, 1, 1), a);
        set_prod(16'd1);
        wait_req(got);
        chk(got, "R3 request issued", 64'(got), 1);
        chk(req_addr == a, "R3 address", req_addr, a);
        chk(req_len == 12'h5EA, "R3 length", 64'(req_len), 64'h5EA);
        chk(req_sop && req_eop && req_crc, "R4 full frame flags",
            {req_sop, req_eop, req_crc}, 64'd7);
        repeat (5) @(negedge clk);
        chk(req_valid && req_addr == a && cons_idx == 0, "R5 held until done",
            {req_valid, cons_idx}, {1'b1, 16'd0});
        pulse_done();
        chk(cons_idx == 1 && cur_slot == 1, "R6 advance after done",
            {cons_idx, cur_slot}, {16'd1, 8'd1});
        chk(!req_valid, "R6 request dropped", 64'(req_valid), 0);
        quiet(10, "R2 quiet once caught up");
    endtask

    task automatic t_order;
        bit got;
        put_desc(1, ctl_word(12'h040, 1, 0, 0), 64'h0000_0001_0000_1000);
        put_desc(2, ctl_word(12'h7FF, 0, 1, 1), 64'h0000_0002_0000_2000);
        set_prod(16'd3);
        wait_req(got);
        chk(got && req_addr == 64'h0000_0001_0000_1000, "R11 first in order",
            req_addr, 64'h0000_0001_0000_1000);
        chk(req_sop && !req_eop && !req_crc, "R4 start-only flags",
            {req_sop, req_eop, req_crc}, 64'd4);
        pulse_done();
        wait_req(got);
        chk(got && req_addr == 64'h0000_0002_0000_2000 && req_len == 12'h7FF,
            "R11 second in order", req_addr, 64'h0000_0002_0000_2000);
        chk(!req_sop && req_eop && req_crc, "R4 end-only flags",
            {req_sop, req_eop, req_crc}, 64'd3);
        pulse_done();
        chk(cons_idx == 3, "R11 consumer reaches producer", 64'(cons_idx), 3);
    endtask

    task automatic t_gate;
        bit got;
        put_desc(3, ctl_word(12'h100, 1, 1, 0), 64'h0000_0003_0000_3000);
        dma_en = 1'b0; ring_en = 1'b1;
        set_prod(16'd4);
        quiet(20, "R7 held by dma enable");
        dma_en = 1'b1; ring_en = 1'b0;
        quiet(20, "R7 held by ring enable");
        ring_en = 1'b1;
        wait_req(got);
        chk(got && req_addr == 64'h0000_0003_0000_3000, "R7 runs when both set",
            req_addr, 64'h0000_0003_0000_3000);
        pulse_done();
    endtask

    task automatic t_stop;
        bit got;
        put_desc(4, ctl_word(12'h200, 1, 1, 0), 64'h0000_0004_0000_4000);
        put_desc(5, ctl_word(12'h300, 1, 1, 0), 64'h0000_0005_0000_5000);
        set_prod(16'd6);
        wait_req(got);
        chk(got && req_addr == 64'h0000_0004_0000_4000, "R8 first request",
            req_addr, 64'h0000_0004_0000_4000);
        dma_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_valid, "R8 request survives disable", 64'(req_valid), 1);
        pulse_done();
        chk(cons_idx == 5, "R8 in-flight counted", 64'(cons_idx), 5);
        quiet(20, "R8 no further fetch");
        chk(eng_idle, "R8 back to idle", 64'(eng_idle), 1);
        dma_en = 1'b1;
        wait_req(got);
        chk(got && req_addr == 64'h0000_0005_0000_5000, "R8 resumes",
            req_addr, 64'h0000_0005_0000_5000);
        pulse_done();
    endtask

    task automatic t_stray;
        pulse_done();
        repeat (2) @(negedge clk);
        chk(cons_idx == 6 && cur_slot == 6, "R10 stray done ignored",
            {cons_idx, cur_slot}, {16'd6, 8'd6});
    endtask

    task automatic t_wrap;
        bit got;
        int bad = 0;
        for (int s = 0; s < 256; s++) begin
            put_desc(s, ctl_word(wrap_len(s), 1, 1, 0), wrap_addr(s));
        end
        set_prod(16'd258);
        for (int i = 6; i < 258; i++) begin
            wait_req(got);
            if (!got || req_addr != wrap_addr(i % 256) || req_len != wrap_len(i % 256)) begin
                if (bad == 0) chk(1'b0, "R9 slot content", req_addr, wrap_addr(i % 256));
                bad++;
            end
            if (i == 255) chk(cur_slot == 8'd255, "R9 last slot", 64'(cur_slot), 255);
            pulse_done();
            if (i == 255) chk(cur_slot == 8'd0, "R9 wrap to zero", 64'(cur_slot), 0);
        end
        chk(bad == 0, "R9 all wrapped requests", 64'(bad), 0);
        chk(cons_idx == 16'd258 && cur_slot == 8'd2, "R9 consumer past ring size",
            {cons_idx, cur_slot}, {16'd258, 8'd2});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_empty();
        t_single();
        t_order();
        t_gate();
        t_stop();
        t_stray();
        t_wrap();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule